// File: doc/BRIEF.md
# Cache Maintenance Range Walker

This block turns one register-level cache maintenance request into a stream of per-line commands for a downstream cache controller. A request is either an address range with an operation code, or a sweep of every index in one way of the data cache. For a range, the walker starts at the line holding the start address and stops at the line holding the end address, and both of those lines are included. For a sweep, it builds set/index words for the chosen way and stops at a limit it derives from the size code in a cache type value.

Before any work starts, the walker checks the access type, the operation code and the caller's privilege. A request that fails a check produces a one-cycle error pulse and no commands. An accepted request holds the request side busy until its last command has been taken over a valid/ready handshake. A one-cycle done pulse then marks the end of the walk. Range addresses go through a context relocation step before the walker aligns them.

Top module: `cmaint_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. It is low from the cycle after a request is accepted until the walk has finished, and it is high again in the cycle that `done` is high.
- R2: A range request produces one command for each 32-byte line, from the line holding the relocated start address to the line holding the relocated end address, both included. Each `cmd_word` has its low 5 bits at zero and is 32 above the word before it.
- R3: If the aligned end address is below the aligned start address, exactly one command is issued, and it is for the start line.
- R4: Range operation codes are 5 (invalidate instruction cache), 6 (invalidate data cache), 12 (clean data cache) and 14 (clean and invalidate data cache). An accepted range request copies its code onto `cmd_op`. Any other code is rejected.
- R5: With `req_priv` low (user mode), only range code 12 is accepted. Every other range code needs `req_priv` high.
- R6: A range request is accepted only when `req_pair` is high (two-register transfer). With `req_pair` low, the request is rejected and issues no commands.
- R7: A way sweep needs `req_priv` high and `req_pair` low, and is rejected otherwise. Its commands carry `cmd_setidx`=1 and `cmd_op`=14, with the way number in `cmd_word[31:30]`. The index starts at 0 and advances by 32.
- R8: A sweep's index limit is 1<<(S+7), where S is `req_ctype[20:18]`. The last command has index limit-32, so a sweep issues 2^(S+2) commands.
- R9: If bits [31:25] of a range address are zero, those bits are replaced by `ctx_id` before alignment. Otherwise the address is used unchanged. This applies to both the start and the end address.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_word`, `cmd_op` and `cmd_setidx` stay unchanged.
- R11: `done` rises for exactly one cycle, in the cycle after the last command is accepted, and `cmd_valid` is low in that cycle.
- R12: A rejected request raises `err` for exactly one cycle, in the cycle after the request, with no `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_sweep | input | 1 | 1 = whole-way sweep, 0 = address range |
| req_pair | input | 1 | Request arrived as a two-register transfer |
| req_priv | input | 1 | Caller is privileged |
| req_op | input | 4 | Range operation code |
| req_start | input | 32 | Range start virtual address |
| req_end | input | 32 | Range end virtual address |
| req_way | input | 2 | Way to sweep |
| req_ctype | input | 32 | Cache type value holding the size code |
| ctx_id | input | 7 | Context identifier used for relocation |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_setidx | output | 1 | 1 = word is set/index, 0 = line address |
| cmd_op | output | 4 | Operation code of the command |
| cmd_word | output | 32 | Line address or set/index word |
| done | output | 1 | One-cycle pulse after the last command |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, 32-byte lines, a 2-bit way field at the top of the word, and a 3-bit size code at bit 18. Small size codes keep sweeps to a few commands, so many sweeps fit in one run. The largest code (512 commands) is run once, which exercises the widest index limit. With these defaults, the 7-bit relocation field covers both the relocated and the untouched address regions. Short random ranges cover the same-line case, the multi-line case and the reversed-range case.

// File: rtl/cmw_pkg.sv
package cmw_pkg;

  typedef logic [3:0] op_t;

  localparam op_t OP_INV_I = 4'd5;
  localparam op_t OP_INV_D = 4'd6;
  localparam op_t OP_CLN_D = 4'd12;
  localparam op_t OP_CIN_D = 4'd14;

  typedef enum logic {ST_IDLE, ST_RUN} walk_st_e;

  function automatic logic op_known(op_t op);
    return (op == OP_INV_I) || (op == OP_INV_D) || (op == OP_CLN_D) || (op == OP_CIN_D);
  endfunction

endpackage

// File: rtl/cmw_gate.sv
module cmw_gate
  import cmw_pkg::*;
(
  input  logic sweep,
  input  logic pair,
  input  logic priv,
  input  op_t  op,
  output logic ok
);

  logic range_ok;
  logic sweep_ok;

  always_comb begin
    // user mode may only clean the data cache by range
    range_ok = pair && op_known(op) && (priv || (op == OP_CLN_D));
    sweep_ok = !pair && priv;
    ok       = sweep ? sweep_ok : range_ok;
  end

endmodule

// File: rtl/cmw_reloc.sv
module cmw_reloc #(
  parameter int AW = 32,
  parameter int RW = 7
) (
  input  logic [AW-1:0] va,
  input  logic [RW-1:0] ctx,
  output logic [AW-1:0] pa
);

  localparam int TOP = AW - RW;

  always_comb begin
    if (va[AW-1:TOP] == '0) pa = {ctx, va[TOP-1:0]};
    else                    pa = va;
  end

endmodule

// File: rtl/cmw_stepper.sv
module cmw_stepper #(
  parameter int AW    = 32,
  parameter int LSH   = 5,
  parameter int WAYW  = 2,
  parameter int SZLSB = 18,
  parameter int SZW   = 3,
  parameter int IBASE = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            sweep,
  input  logic            adv,
  input  logic [AW-1:0]   start_pa,
  input  logic [AW-1:0]   end_pa,
  input  logic [AW-1:0]   ctype,
  input  logic [WAYW-1:0] way,
  output logic [AW-1:0]   word,
  output logic            last
);

  localparam logic [AW-1:0] STEP = AW'(1) << LSH;

  logic [AW-1:0]  cur;
  logic [AW-1:0]  stop;
  logic [AW-1:0]  s_al;
  logic [AW-1:0]  e_al;
  logic [AW-1:0]  lim;
  logic [AW-1:0]  way_base;
  logic [SZW-1:0] szc;

  always_comb begin
    s_al     = {start_pa[AW-1:LSH], {LSH{1'b0}}};
    e_al     = {end_pa[AW-1:LSH], {LSH{1'b0}}};
    szc      = ctype[SZLSB +: SZW];
    lim      = AW'(1) << (32'(szc) + IBASE);
    way_base = {way, {(AW-WAYW){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      stop <= '0;
    end else if (load) begin
      if (sweep) begin
        cur  <= way_base;
        stop <= way_base | (lim - STEP);
      end else begin
        cur  <= s_al;
        stop <= (e_al < s_al) ? s_al : e_al;
      end
    end else if (adv) begin
      cur <= cur + STEP;
    end
  end

  assign word = cur;
  assign last = (cur == stop);

  // each advance moves exactly one line / index step
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (word == $past(word) + STEP));

endmodule

// File: rtl/cmaint_walker.sv
module cmaint_walker
  import cmw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CTX_W      = 7,
  parameter int LINE_SHIFT = 5,
  parameter int WAY_W      = 2,
  parameter int SIZE_LSB   = 18,
  parameter int SIZE_W     = 3,
  parameter int IDX_BASE   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_sweep,
  input  logic              req_pair,
  input  logic              req_priv,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [ADDR_W-1:0] req_ctype,
  input  logic [CTX_W-1:0]  ctx_id,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_setidx,
  output logic [3:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_word,
  output logic              done,
  output logic              err
);

  walk_st_e          st;
  logic              gate_ok;
  logic              take;
  logic              load;
  logic              adv;
  logic              cmd_last;
  logic [ADDR_W-1:0] start_pa;
  logic [ADDR_W-1:0] end_pa;

  cmw_gate u_gate (
    .sweep (req_sweep),
    .pair  (req_pair),
    .priv  (req_priv),
    .op    (req_op),
    .ok    (gate_ok)
  );

  cmw_reloc #(.AW(ADDR_W), .RW(CTX_W)) u_reloc_s (
    .va  (req_start),
    .ctx (ctx_id),
    .pa  (start_pa)
  );

  cmw_reloc #(.AW(ADDR_W), .RW(CTX_W)) u_reloc_e (
    .va  (req_end),
    .ctx (ctx_id),
    .pa  (end_pa)
  );

  assign req_ready = (st == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign load      = take && gate_ok;
  assign adv       = cmd_valid && cmd_ready && !cmd_last;

  cmw_stepper #(
    .AW    (ADDR_W),
    .LSH   (LINE_SHIFT),
    .WAYW  (WAY_W),
    .SZLSB (SIZE_LSB),
    .SZW   (SIZE_W),
    .IBASE (IDX_BASE)
  ) u_step (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .sweep    (req_sweep),
    .adv      (adv),
    .start_pa (start_pa),
    .end_pa   (end_pa),
    .ctype    (req_ctype),
    .way      (req_way),
    .word     (cmd_word),
    .last     (cmd_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cmd_valid  <= 1'b0;
      cmd_setidx <= 1'b0;
      cmd_op     <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take) begin
            if (gate_ok) begin
              st         <= ST_RUN;
              cmd_valid  <= 1'b1;
              cmd_setidx <= req_sweep;
              cmd_op     <= req_sweep ? OP_CIN_D : req_op;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (cmd_ready && cmd_last) begin
            st        <= ST_IDLE;
            cmd_valid <= 1'b0;
            done      <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_busy_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_word) && $stable(cmd_op) && $stable(cmd_setidx)));

  p_done_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_last) |=> (done && !cmd_valid));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_reject_r12: assert property (@(posedge clk) disable iff (rst)
    (take && !gate_ok) |=> (err && !cmd_valid));

  p_err_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

endmodule

// File: tb/test_cmaint_walker.sv
module test_cmaint_walker;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_sweep, req_pair, req_priv;
  logic [3:0]  req_op;
  logic [31:0] req_start, req_end, req_ctype;
  logic [1:0]  req_way;
  logic [6:0]  ctx_id;
  logic        cmd_valid, cmd_ready, cmd_setidx;
  logic [3:0]  cmd_op;
  logic [31:0] cmd_word;
  logic        done, err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cmaint_walker i_cmaint_walker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_sweep(req_sweep),
    .req_pair(req_pair), .req_priv(req_priv), .req_op(req_op),
    .req_start(req_start), .req_end(req_end), .req_way(req_way),
    .req_ctype(req_ctype), .ctx_id(ctx_id),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_setidx(cmd_setidx),
    .cmd_op(cmd_op), .cmd_word(cmd_word), .done(done), .err(err)
  );

  task automatic chk(bit c, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_reloc(logic [31:0] va, logic [6:0] cx);
    return (va[31:25] == 7'd0) ? {cx, va[24:0]} : va;
  endfunction

  function automatic bit f_ok(bit sw, bit pair, bit priv, logic [3:0] op);
    bit known;
    known = (op == 4'd5) || (op == 4'd6) || (op == 4'd12) || (op == 4'd14);
    if (sw) return !pair && priv;
    return pair && known && (priv || op == 4'd12);
  endfunction

  task automatic do_req(bit sw, bit pair, bit priv, logic [3:0] op,
                        logic [31:0] s, logic [31:0] e, logic [1:0] way,
                        logic [31:0] ct, logic [6:0] cx, int stall, string tag);
    bit          ok;
    logic [31:0] first, sa, ea;
    int          cnt, n, guard;
    bit          r;
    ok = f_ok(sw, pair, priv, op);
    if (sw) begin
      first = {way, 30'd0};
      cnt   = 1 << (int'(ct[20:18]) + 2);
    end else begin
      sa = f_reloc(s, cx) & 32'hFFFF_FFE0;
      ea = f_reloc(e, cx) & 32'hFFFF_FFE0;
      if (ea < sa) ea = sa;
      first = sa;
      cnt   = int'((ea - sa) >> 5) + 1;
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 idle ready", 32'(req_ready), 32'd1);
    req_sweep = sw; req_pair = pair; req_priv = priv; req_op = op;
    req_start = s; req_end = e; req_way = way; req_ctype = ct; ctx_id = cx;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!ok) begin
      chk(err === 1'b1, tag, 32'(err), 32'd1);
      chk(cmd_valid === 1'b0, tag, 32'(cmd_valid), 32'd0);
      @(negedge clk);
      chk(err === 1'b0, "R12 err pulse", 32'(err), 32'd0);
      chk(cmd_valid === 1'b0, "R12 no cmd", 32'(cmd_valid), 32'd0);
      return;
    end
    chk(req_ready === 1'b0, "R1 busy", 32'(req_ready), 32'd0);
    n = 0; guard = 0;
    while (n < cnt && guard < 20000) begin
      guard++;
      chk(cmd_valid === 1'b1, tag, 32'(cmd_valid), 32'd1);
      chk(cmd_word === first + 32'(n * 32), tag, cmd_word, first + 32'(n * 32));
      chk(cmd_op === (sw ? 4'd14 : op), "R4 op", 32'(cmd_op), 32'(sw ? 4'd14 : op));
      chk(cmd_setidx === sw, "R7 kind", 32'(cmd_setidx), 32'(sw));
      chk(done === 1'b0, "R11 early", 32'(done), 32'd0);
      r = (($urandom % 100) >= stall);
      cmd_ready = r;
      @(negedge clk);
      if (r) n++;
    end
    cmd_ready = 1'b0;
    chk(done === 1'b1, "R11 done", 32'(done), 32'd1);
    chk(cmd_valid === 1'b0, "R11 end", 32'(cmd_valid), 32'd0);
    chk(req_ready === 1'b1, "R1 free", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk(done === 1'b0, "R11 pulse", 32'(done), 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; req_valid = 0; req_sweep = 0; req_pair = 0; req_priv = 0;
    req_op = 0; req_start = 0; req_end = 0; req_way = 0; req_ctype = 0;
    ctx_id = 0; cmd_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_valid === 1'b0, "R11 reset valid", 32'(cmd_valid), 32'd0);
    chk(done === 1'b0, "R11 reset done", 32'(done), 32'd0);
    chk(err === 1'b0, "R12 reset err", 32'(err), 32'd0);
    chk(req_ready === 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);

    // directed corners
    do_req(0, 1, 1, 4'd6, 32'h0100_0044, 32'h0100_00A0, 0, 0, 7'h00, 20, "R2 multi-line");
    do_req(0, 1, 1, 4'd5, 32'h0000_1010, 32'h0000_1030, 0, 0, 7'h05, 0, "R9 relocated");
    do_req(0, 1, 1, 4'd14, 32'h8000_0004, 32'h8000_0024, 0, 0, 7'h05, 0, "R9 untouched");
    do_req(0, 1, 1, 4'd6, 32'h9000_0100, 32'h9000_0020, 0, 0, 7'h00, 30, "R3 reversed");
    do_req(0, 1, 1, 4'd6, 32'h9000_0101, 32'h9000_011F, 0, 0, 7'h00, 0, "R2 same line");
    do_req(0, 1, 0, 4'd12, 32'hA000_0000, 32'hA000_0040, 0, 0, 7'h00, 0, "R5 user clean");
    do_req(0, 1, 0, 4'd6, 32'hA000_0000, 32'hA000_0040, 0, 0, 7'h00, 0, "R5 user reject");
    do_req(0, 0, 1, 4'd14, 32'hA000_0000, 32'hA000_0040, 0, 0, 7'h00, 0, "R6 single xfer");
    do_req(0, 1, 1, 4'd7, 32'hA000_0000, 32'hA000_0040, 0, 0, 7'h00, 0, "R4 bad code");
    do_req(1, 0, 1, 4'd0, 0, 0, 2'd3, 32'h0000_0000, 7'h00, 10, "R8 size0 way3");
    do_req(1, 0, 1, 4'd0, 0, 0, 2'd1, 32'hFFE3_FFFF | (32'd7 << 18), 7'h00, 5, "R8 size7");
    do_req(1, 0, 0, 4'd0, 0, 0, 2'd2, 0, 7'h00, 0, "R7 user sweep");
    do_req(1, 1, 1, 4'd0, 0, 0, 2'd2, 0, 7'h00, 0, "R7 pair sweep");
    do_req(0, 1, 1, 4'd12, 32'hB000_0000, 32'hB000_00E0, 0, 0, 7'h00, 75, "R10 stalls");

    // constrained random mix
    for (int i = 0; i < 150; i++) begin
      bit          sw, pair, priv;
      logic [3:0]  op;
      logic [31:0] base, s, e;
      int          d;
      sw   = ($urandom % 4) == 0;
      pair = ($urandom % 5) != 0 ? !sw : sw;
      priv = ($urandom % 4) != 0;
      case ($urandom % 6)
        0: op = 4'd5; 1: op = 4'd6; 2: op = 4'd12; 3: op = 4'd14;
        default: op = 4'($urandom);
      endcase
      base = ($urandom % 2) ? 32'd0 : {7'(($urandom % 127) + 1), 25'd0};
      s    = base | ($urandom & 32'h00FF_FF00) | 32'h100 | ($urandom & 32'h1F);
      d    = int'($urandom % 320) - 64;
      e    = s + 32'(d);
      do_req(sw, pair, priv, op, s, e, 2'($urandom), 32'($urandom % 4) << 18,
             7'($urandom), int'($urandom % 50), sw ? "R8 random sweep" : "R2 random range");
    end
    finish_run();
  end

endmodule